// File: doc/BRIEF.md
# Configurable serial transmitter

This block turns one data word per handshake into an asynchronous serial frame on a single output line. A word of 8 or 9 bits is taken from an upstream buffer through a valid/ready pair. The block sends a low start bit, then the data bits least significant first, then an optional parity bit, then a high stop period. The line rests high whenever no frame is in flight, and it is also high during reset.

The frame format comes from four static configuration fields: baud select, parity type, stop length and data length. All four are captured when a word is accepted, so a change made in the middle of a frame only applies to the next one. Bit timing comes from a half-bit counter whose limit is derived from the `CLK_HZ` parameter, which is 50 MHz by default. The half-bit granularity is what lets the stop period last one and a half bits. A busy flag covers the whole frame, and a one-cycle done pulse marks the end of the stop period.

Top module: `uart_tx`

## Requirements
- R1: While `rst_n` is low, and whenever no frame is in progress, `tx_line` is 1, `tx_busy` is 0 and `tx_done` is 0. Out of reset, `in_ready` is 1.
- R2: A word is accepted on a rising clock edge where `in_valid` and `in_ready` are both 1. From that edge until the frame ends, `in_ready` is 0 and `tx_busy` is 1, and the data and configuration inputs are ignored.
- R3: The frame is sent in this order: a start bit of 0, then the data bits least significant first, then the parity bit if one is enabled, then the stop period at 1. `cfg_len9` = 0 sends `in_data[7:0]` and `cfg_len9` = 1 sends `in_data[8:0]`.
- R4: `cfg_parity` 00 sends no parity bit. Code 01 (even) sends the XOR of the data bits that are sent. Code 10 (odd) sends the inverse of that XOR.
- R5: The stop period lasts 2, 3 or 4 half-bit periods for `cfg_stop` 00, 01 and 10. `tx_done` is 1 for exactly one cycle, in the first cycle after the stop period, and `in_ready` returns to 1 in that same cycle.
- R6: `cfg_baud` 00, 01, 10 and 11 select 19200, 9600, 4800 and 2400 bit/s. One half-bit period is H = CLK_HZ/(2·rate) clock cycles, rounded to the nearest integer, and each bit lasts 2·H cycles.
- R7: At the default CLK_HZ of 50 MHz, the measured bit rate at every baud select is within ±0.5 % of nominal.
- R8: The data and configuration are captured at the accepting edge. Input changes during the frame do not alter the frame being sent.
- R9: The reserved code `cfg_parity` = 11 behaves as no parity. The reserved code `cfg_stop` = 11 behaves as a stop period of 4 half-bit periods.
- R10: `tx_line` is driven low at the accepting edge. With N data bits and P parity bits, `tx_done` rises 2·H·(1+N+P) + H·S cycles after that edge, where S is the stop length in half-bit periods. If `in_valid` is held high, the next word is accepted on the edge that immediately follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Upstream has a word available |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_data | input | 9 | Word to send (bit 8 is used only in 9-bit mode) |
| cfg_baud | input | 2 | Baud select: 00 = 19200, 01 = 9600, 10 = 4800, 11 = 2400 |
| cfg_parity | input | 2 | Parity: 00 = none, 01 = even, 10 = odd, 11 = none |
| cfg_stop | input | 2 | Stop length: 00 = 1 bit, 01 = 1.5 bits, 10 and 11 = 2 bits |
| cfg_len9 | input | 1 | 0 = 8 data bits, 1 = 9 data bits |
| tx_line | output | 1 | Serial output, high when idle |
| tx_busy | output | 1 | A frame is in progress |
| tx_done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
Two situations are hard to reach from the ports. The first is a frame disturbed while it is still being sent. The stimulus keeps `in_valid` high for the whole frame and puts fresh random data and configuration on the inputs every cycle. The expected line, compared cycle by cycle, must still come only from the word that was accepted.

The second is the full timing of the slow rates at the real 50 MHz clock, because one whole frame at 2400 bit/s would exceed the run budget. A second instance at the default clock therefore sends a word whose data bits are all 1. The bench measures only the start-bit width and then aborts the frame with that instance's own reset. A scaled-clock instance covers every format combination, the reserved codes and a back-to-back handover.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int unsigned DATA_W  = 9;
  localparam int unsigned FRAME_W = 11;
  localparam int unsigned BITS_W  = 4;

  typedef enum logic [1:0] {ST_IDLE, ST_BITS, ST_STOP} tx_state_e;

  function automatic int unsigned baud_of(input logic [1:0] sel);
    case (sel)
      2'b00:   return 19200;
      2'b01:   return 9600;
      2'b10:   return 4800;
      default: return 2400;
    endcase
  endfunction

  // nearest-integer half-bit divisor
  function automatic int unsigned half_div(input int unsigned clk_hz, input logic [1:0] sel);
    return (clk_hz + baud_of(sel)) / (2 * baud_of(sel));
  endfunction

  function automatic logic [2:0] stop_halves(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd2;
      2'b01:   return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic par_on(input logic [1:0] mode);
    return (mode == 2'b01) || (mode == 2'b10);
  endfunction

  function automatic logic par_bit(input logic [DATA_W-1:0] data, input logic len9,
                                   input logic [1:0] mode);
    logic x;
    x = (^data[7:0]) ^ (len9 & data[8]);
    return (mode == 2'b10) ? ~x : x;
  endfunction

  function automatic logic [BITS_W-1:0] frame_bits(input logic len9, input logic [1:0] mode);
    return BITS_W'(9) + BITS_W'(len9) + BITS_W'(par_on(mode));
  endfunction

endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud
  import uart_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned CNT_W  = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clear,
  input  logic [1:0] sel,
  output logic       half_tick
);

  logic [CNT_W-1:0] lim_tab [4];
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    assign lim_tab[g] = CNT_W'(half_div(CLK_HZ, 2'(g)) - 1);
  end

  assign limit     = lim_tab[sel];
  assign half_tick = run && !clear && (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || clear || !run) cnt <= '0;
    else if (cnt == limit)       cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  // R6
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt <= limit));

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
(
  input  logic [DATA_W-1:0]  data,
  input  logic               len9,
  input  logic [1:0]         mode,
  output logic [FRAME_W-1:0] vec,
  output logic [BITS_W-1:0]  nbits
);

  logic par;
  logic pen;

  assign par   = par_bit(data, len9, mode);
  assign pen   = par_on(mode);
  assign nbits = frame_bits(len9, mode);

  always_comb begin
    vec    = '1;
    vec[0] = 1'b0;
    if (len9) begin
      vec[9:1] = data;
      if (pen) vec[10] = par;
    end else begin
      vec[8:1] = data[7:0];
      if (pen) vec[9] = par;
    end
  end

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
  import uart_tx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [FRAME_W-1:0] vec,
  input  logic [BITS_W-1:0]  nbits,
  input  logic [1:0]         stop_code,
  input  logic [1:0]         baud_sel,
  input  logic               half_tick,
  output logic               in_ready,
  output logic               busy,
  output logic               done,
  output logic               tx,
  output logic [1:0]         sel_q,
  output logic               accept
);

  tx_state_e          state;
  logic [FRAME_W-2:0] sreg;
  logic [BITS_W-1:0]  bits_left;
  logic               phase;
  logic [2:0]         halves_left;
  logic               bit_end;
  logic               frame_end;

  assign in_ready  = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign accept    = in_valid && in_ready;
  assign bit_end   = (state == ST_BITS) && half_tick && phase;
  assign frame_end = (state == ST_STOP) && half_tick && (halves_left == 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      sreg        <= '1;
      bits_left   <= '0;
      phase       <= 1'b0;
      halves_left <= '0;
      tx          <= 1'b1;
      done        <= 1'b0;
      sel_q       <= '0;
    end else begin
      done <= frame_end;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            sreg        <= vec[FRAME_W-1:1];
            tx          <= vec[0];
            bits_left   <= nbits;
            phase       <= 1'b0;
            halves_left <= stop_halves(stop_code);
            sel_q       <= baud_sel;
            state       <= ST_BITS;
          end
        end
        ST_BITS: begin
          if (half_tick) phase <= ~phase;
          if (bit_end) begin
            sreg      <= {1'b1, sreg[FRAME_W-2:1]};
            bits_left <= bits_left - 1'b1;
            if (bits_left == BITS_W'(1)) begin
              state <= ST_STOP;
              tx    <= 1'b1;
            end else begin
              tx <= sreg[0];
            end
          end
        end
        default: begin
          if (half_tick) begin
            halves_left <= halves_left - 3'd1;
            if (frame_end) state <= ST_IDLE;
          end
        end
      endcase
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!tx && busy));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && tx));

  // R5
  stop_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP) |-> tx);

endmodule

// File: rtl/uart_tx.sv
module uart_tx
  import uart_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        cfg_baud,
  input  logic [1:0]        cfg_parity,
  input  logic [1:0]        cfg_stop,
  input  logic              cfg_len9,
  output logic              tx_line,
  output logic              tx_busy,
  output logic              tx_done
);

  localparam int unsigned HMAX  = half_div(CLK_HZ, 2'b11);
  localparam int unsigned CNT_W = $clog2(HMAX + 1);

  logic [FRAME_W-1:0] vec;
  logic [BITS_W-1:0]  nbits;
  logic [1:0]         sel_q;
  logic               accept;
  logic               half_tick;

  uart_tx_framer u_framer (
    .data  (in_data),
    .len9  (cfg_len9),
    .mode  (cfg_parity),
    .vec   (vec),
    .nbits (nbits)
  );

  uart_tx_baud #(.CLK_HZ(CLK_HZ), .CNT_W(CNT_W)) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (tx_busy),
    .clear     (accept),
    .sel       (sel_q),
    .half_tick (half_tick)
  );

  uart_tx_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .vec       (vec),
    .nbits     (nbits),
    .stop_code (cfg_stop),
    .baud_sel  (cfg_baud),
    .half_tick (half_tick),
    .in_ready  (in_ready),
    .busy      (tx_busy),
    .done      (tx_done),
    .tx        (tx_line),
    .sel_q     (sel_q),
    .accept    (accept)
  );

endmodule

// File: tb/test_uart_tx.sv
module test_uart_tx;

  localparam int unsigned SIM_HZ = 960_000;
  localparam int unsigned NOM_HZ = 50_000_000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, in_valid = 1'b0, cfg_len9 = 1'b0;
  logic [8:0] in_data = '0;
  logic [1:0] cfg_baud = '0, cfg_parity = '0, cfg_stop = '0;
  logic       in_ready, tx_line, tx_busy, tx_done;

  logic       n_rst = 1'b0, n_valid = 1'b0;
  logic [8:0] n_data = '0;
  logic [1:0] n_baud = '0;
  logic       n_ready, n_tx, n_busy, n_done;

  int checks = 0;
  int fails  = 0;

  uart_tx #(.CLK_HZ(SIM_HZ)) i_uart_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_baud(cfg_baud), .cfg_parity(cfg_parity),
    .cfg_stop(cfg_stop), .cfg_len9(cfg_len9), .tx_line(tx_line),
    .tx_busy(tx_busy), .tx_done(tx_done)
  );

  uart_tx i_uart_tx_nom (
    .clk(clk), .rst_n(n_rst), .in_valid(n_valid), .in_ready(n_ready),
    .in_data(n_data), .cfg_baud(n_baud), .cfg_parity(2'b00),
    .cfg_stop(2'b00), .cfg_len9(1'b0), .tx_line(n_tx),
    .tx_busy(n_busy), .tx_done(n_done)
  );

  function automatic int unsigned b_rate(input logic [1:0] s);
    return (s == 2'd0) ? 19200 : (s == 2'd1) ? 9600 : (s == 2'd2) ? 4800 : 2400;
  endfunction

  function automatic int unsigned b_half(input int unsigned hz, input logic [1:0] s);
    int unsigned q, r, d;
    d = 2 * b_rate(s);
    q = hz / d;
    r = hz % d;
    if (2 * r >= d) q = q + 1;
    return q;
  endfunction

  function automatic int unsigned b_halves(input logic [1:0] c);
    return (c == 2'd0) ? 2 : (c == 2'd1) ? 3 : 4;
  endfunction

  function automatic int unsigned b_pen(input logic [1:0] m);
    return (m == 2'd1 || m == 2'd2) ? 1 : 0;
  endfunction

  function automatic logic exp_bit(input int k, input logic [8:0] d, input logic l9,
                                   input logic [1:0] pm);
    int n, ones;
    n = l9 ? 9 : 8;
    if (k == 0) return 1'b0;
    if (k <= n) return d[k-1];
    if (k == n + 1 && b_pen(pm) == 1) begin
      ones = $countones(l9 ? d : {1'b0, d[7:0]});
      return (pm == 2'd1) ? logic'(ones % 2) : logic'(1 - ones % 2);
    end
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic put(input logic [8:0] d, input logic [1:0] b, p, s, input logic l);
    in_valid = 1'b1; in_data = d; cfg_baud = b; cfg_parity = p; cfg_stop = s; cfg_len9 = l;
  endtask

  // inputs for this frame must already be on the pins with in_valid high
  task automatic do_frame(input logic [8:0] d, input logic [1:0] b, p, s, input logic l,
                          input bit hold, input logic [8:0] nd, input logic [1:0] nb, np, ns,
                          input logic nl, input string ltag, input string ctag);
    int h, nbt, t, lim, bad_l, bad_c, bad_m;
    logic e;
    h   = b_half(SIM_HZ, b);
    nbt = 1 + (l ? 9 : 8) + b_pen(p);
    t   = 2 * h * nbt + h * b_halves(s);
    lim = hold ? t : t + 2;
    bad_l = 0; bad_c = 0; bad_m = -1;
    @(posedge clk);
    for (int m = 0; m <= lim; m++) begin
      @(negedge clk);
      e = (m < 2 * h * nbt) ? exp_bit(m / (2 * h), d, l, p) : 1'b1;
      if (tx_line !== e) begin bad_l++; if (bad_m < 0) bad_m = m; end
      if (tx_done !== (m == t)) bad_c++;
      if (tx_busy !== (m < t))  bad_c++;
      if (in_ready !== (m >= t)) bad_c++;
      if (m < t) begin
        in_data = 9'($urandom); cfg_baud = 2'($urandom); cfg_parity = 2'($urandom);
        cfg_stop = 2'($urandom); cfg_len9 = 1'($urandom);
      end else if (m == t) begin
        if (hold) put(nd, nb, np, ns, nl);
        else in_valid = 1'b0;
      end
    end
    chk(bad_l == 0, ltag, "line mismatches (first at cycle shown in expected)", bad_l, bad_m);
    chk(bad_c == 0, ctag, "done/busy/ready mismatches", bad_c, 0);
  endtask

  task automatic nom_measure(input logic [1:0] sel);
    int l;
    longint rate, err;
    n_rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(n_tx === 1'b1, "R1", "line high in reset (nominal)", n_tx, 1);
    n_rst = 1'b1;
    @(negedge clk);
    n_valid = 1'b1; n_data = 9'h1FF; n_baud = sel;
    @(posedge clk);
    @(negedge clk);
    n_valid = 1'b0;
    l = 0;
    while (n_tx === 1'b0 && l < 30000) begin
      l++;
      @(negedge clk);
    end
    chk(l == 2 * b_half(NOM_HZ, sel), "R6", "start bit cycles at 50 MHz", l, 2 * b_half(NOM_HZ, sel));
    rate = longint'(b_rate(sel)) * l;
    err  = (rate > NOM_HZ) ? rate - NOM_HZ : NOM_HZ - rate;
    chk(err * 200 <= rate, "R7", "rate error x200 vs bit rate x cycles", err * 200, rate);
    n_rst = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

  initial begin
    logic [8:0] d;
    logic [1:0] b, p, s;
    logic l;
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    chk(tx_line === 1'b1, "R1", "line in reset", tx_line, 1);
    chk(tx_busy === 1'b0, "R1", "busy in reset", tx_busy, 0);
    chk(tx_done === 1'b0, "R1", "done in reset", tx_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R1", "ready after reset", in_ready, 1);
    chk(tx_line === 1'b1, "R1", "line idle after reset", tx_line, 1);

    put(9'h0A5, 2'd0, 2'd0, 2'd0, 1'b0);
    do_frame(9'h0A5, 2'd0, 2'd0, 2'd0, 1'b0, 0, '0, '0, '0, '0, 1'b0, "R3 R6 R8", "R2 R5");
    put(9'h1C3, 2'd1, 2'd1, 2'd1, 1'b1);
    do_frame(9'h1C3, 2'd1, 2'd1, 2'd1, 1'b1, 0, '0, '0, '0, '0, 1'b0, "R3 R4 R8", "R2 R5");
    put(9'h0FF, 2'd2, 2'd2, 2'd2, 1'b0);
    do_frame(9'h0FF, 2'd2, 2'd2, 2'd2, 1'b0, 0, '0, '0, '0, '0, 1'b0, "R4 R6", "R5");
    put(9'h155, 2'd3, 2'd3, 2'd3, 1'b1);
    do_frame(9'h155, 2'd3, 2'd3, 2'd3, 1'b1, 0, '0, '0, '0, '0, 1'b0, "R9 line", "R9 timing");
    put(9'h000, 2'd0, 2'd1, 2'd0, 1'b0);
    do_frame(9'h000, 2'd0, 2'd1, 2'd0, 1'b0, 1, 9'h13C, 2'd0, 2'd2, 2'd1, 1'b1, "R4", "R10 first");
    do_frame(9'h13C, 2'd0, 2'd2, 2'd1, 1'b1, 0, '0, '0, '0, '0, 1'b0, "R10 line", "R10 timing");

    for (int i = 0; i < 20; i++) begin
      d = 9'($urandom); b = 2'($urandom); p = 2'($urandom);
      s = 2'($urandom); l = 1'($urandom);
      put(d, b, p, s, l);
      do_frame(d, b, p, s, l, 0, '0, '0, '0, '0, 1'b0, "R3 R4 R6 R8", "R2 R5 R10");
    end

    for (int k = 0; k < 4; k++) nom_measure(2'(k));
    report();
  end

endmodule